// File: doc/BRIEF.md
# Stream Stall Timeout Timer

This block guards one channel of a memory-to-stream DMA engine against a stream sink that stops accepting data for too long. A stall exists when the timer is enabled, the channel still has data left to move, and the sink reports that it is not ready. When a stall begins, the block captures two programmed values. The first is a prescale value P, which makes one tick every P+1 clock cycles. The second is a limit T, which sets how many ticks the stall may last. If the stall is still present when the limit is used up, the block raises a single-cycle timeout pulse.

The timer does not restart by itself after it fires. Another pulse can only come after the stall has ended, because the sink became ready, the transfer finished or the enable was cleared, and a new stall has begun. Each new stall starts the count from the beginning, using the values present on the configuration inputs at that moment. Interrupt masking and the DMA datapath are handled by the surrounding logic.

Top module: `stall_timeout_timer`

## Requirements
- R1: A stall is present in a cycle exactly when `enable_i` is 1, `pending_i` is 1 and `sink_ready_i` is 0. The timer arms only on a cycle in which a stall is present.
- R2: While the timer is armed, ticks occur every `prescale_i`+1 clock cycles, counting `prescale_i` as an unsigned value. A prescale of 0 gives one tick per cycle.
- R3: While `enable_i` is 0, `timeout_o` stays 0. This includes the case where a count was in progress. Clearing the enable drops the count.
- R4: If the sink becomes ready or `pending_i` falls during a stall, the count is dropped. A later stall counts again from the full programmed values.
- R5: Call the clock edge on which the arming stall is first sampled edge 0. If the stall continues without a break, `timeout_o` is 1 only in the cycle that follows edge (P+1)*(T+1), where P is `prescale_i` and T is `limit_i`, both captured at arming.
- R6: `timeout_o` is high for exactly one cycle for each stall. It does not fire again while the same stall continues.
- R7: Changes to `prescale_i` or `limit_i` while the timer is armed have no effect on the count in progress.
- R8: Reset is synchronous and active high. After reset, `timeout_o` is 0 and the timer is idle.
- R9: After a timeout, ending the stall and starting a new one arms the timer again, and the new stall gets its own pulse after the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Timer enable |
| pending_i | input | 1 | Channel has a nonzero remaining transfer size |
| sink_ready_i | input | 1 | Stream sink can accept data |
| prescale_i | input | PRE_W (12) | Tick period minus one, in clock cycles |
| limit_i | input | LIM_W (12) | Number of ticks allowed, minus one |
| timeout_o | output | 1 | One-cycle timeout pulse |

## Verification
The bench measures the exact cycle of the pulse for several pairs of P and T, including P=0 and T=0. A design that is off by one in either count fires one cycle or one whole tick early or late. It keeps a stall running long after expiry, so a design that reloads automatically shows a second pulse. It breaks stalls with sink readiness, with a falling pending flag and with a cleared enable, and then checks that the next stall needs the full interval again; a design that pauses its count instead of dropping it fires early. It also changes the programmed values in the middle of a count, so a design that reads them live fires at the wrong time.

// File: rtl/stall_timeout_pkg.sv
package stall_timeout_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SPENT = 2'd2
    } arm_state_e;

    function automatic logic stall_now(input logic en, input logic pend, input logic rdy);
        return en & pend & ~rdy;
    endfunction

endpackage

// File: rtl/sto_arm_ctrl.sv
module sto_arm_ctrl
    import stall_timeout_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic stall_i,
    input  logic expire_i,
    output logic load_o,
    output logic run_o
);

    arm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!stall_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_RUN;
                ST_RUN:   state_d = expire_i ? ST_SPENT : ST_RUN;
                ST_SPENT: state_d = ST_SPENT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    assign load_o = (state_q == ST_IDLE) && stall_i;
    assign run_o  = (state_q == ST_RUN) && stall_i;

    // R6: once the limit is reached, the same stall is spent
    a_r6_spent_after_expire: assert property (@(posedge clk_i) disable iff (rst_i)
        expire_i |=> state_q == ST_SPENT);

    // R4: a stall that ends leaves the timer idle
    a_r4_idle_after_release: assert property (@(posedge clk_i) disable iff (rst_i)
        !stall_i |=> state_q == ST_IDLE);

endmodule

// File: rtl/sto_prescaler.sv
module sto_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             tick_o
);

    localparam logic [PRE_W-1:0] PRE_INIT = '1;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] hold_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= PRE_INIT;
            hold_q <= PRE_INIT;
        end else if (load_i) begin
            cnt_q  <= pre_i;
            hold_q <= pre_i;
        end else if (run_i) begin
            if (cnt_q == '0) cnt_q <= hold_q;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == '0);

    // R2: a tick only comes while the count is armed
    a_r2_tick_needs_run: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |-> !load_i);

endmodule

// File: rtl/sto_limit_counter.sv
module sto_limit_counter #(
    parameter int LIM_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             tick_i,
    input  logic [LIM_W-1:0] lim_i,
    output logic             expire_o
);

    localparam logic [LIM_W-1:0] LIM_INIT = ~LIM_W'(1);

    logic [LIM_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= LIM_INIT;
        end else if (load_i) begin
            cnt_q <= lim_i;
        end else if (tick_i && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire_o = tick_i && (cnt_q == '0);

    // R7: the count in progress moves only on ticks or a fresh arm
    a_r7_count_frozen: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/stall_timeout_timer.sv
module stall_timeout_timer
    import stall_timeout_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int LIM_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             enable_i,
    input  logic             pending_i,
    input  logic             sink_ready_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             timeout_o
);

    logic stall, load, run, tick, expire;

    assign stall = stall_now(enable_i, pending_i, sink_ready_i);

    sto_arm_ctrl u_arm (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .stall_i  (stall),
        .expire_i (expire),
        .load_o   (load),
        .run_o    (run)
    );

    sto_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .run_i  (run),
        .pre_i  (prescale_i),
        .tick_o (tick)
    );

    sto_limit_counter #(.LIM_W(LIM_W)) u_lim (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .load_i   (load),
        .tick_i   (tick),
        .lim_i    (limit_i),
        .expire_o (expire)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) timeout_o <= 1'b0;
        else       timeout_o <= expire;
    end

    // R3: no pulse follows a cycle with the enable clear
    a_r3_quiet_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> !timeout_o);

    // R4: sink readiness or no pending data suppresses the pulse
    a_r4_ready_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (sink_ready_i || !pending_i) |=> !timeout_o);

    // R6: the pulse lasts a single cycle
    a_r6_single_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_o |=> !timeout_o);

    // R1: a pulse is always preceded by a stall
    a_r1_pulse_from_stall: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(timeout_o) |-> $past(stall));

endmodule

// File: tb/sim_stall_timeout_timer.sv
`timescale 1ns/1ps
module sim_stall_timeout_timer;

    logic        clk = 1'b0;
    logic        rst;
    logic        en, pend, rdy;
    logic [11:0] pre, lim;
    logic        tmo;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stall_timeout_timer u0 (
        .clk_i        (clk),
        .rst_i        (rst),
        .enable_i     (en),
        .pending_i    (pend),
        .sink_ready_i (rdy),
        .prescale_i   (pre),
        .limit_i      (lim),
        .timeout_o    (tmo)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Observe n cycles after the current inputs; k counts edges from 0.
    task automatic observe(input int n, output int first, output int cnt);
        first = -1;
        cnt = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tmo) begin
                cnt++;
                if (first < 0) first = k;
            end
        end
    endtask

    task automatic release_all();
        en = 1'b1; pend = 1'b0; rdy = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        int f, c;
        rst = 1'b1; en = 1'b1; pend = 1'b1; rdy = 1'b0; pre = 12'd0; lim = 12'd0;
        @(negedge clk);
        chk("R8 reset output", int'(tmo), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0; pend = 1'b0; rdy = 1'b1;
        observe(10, f, c);
        chk("R8 idle after reset", c, 0);
    endtask

    task automatic t_interval(input int p, input int t, input string tag);
        int f, c;
        pre = 12'(p); lim = 12'(t);
        en = 1'b1; pend = 1'b1; rdy = 1'b0;
        observe((p + 1) * (t + 1) + 5, f, c);
        chk({tag, " pulse cycle"}, f, (p + 1) * (t + 1));
        chk({tag, " pulse count"}, c, 1);
        release_all();
    endtask

    task automatic t_one_shot();
        int f, c;
        pre = 12'd1; lim = 12'd1;
        en = 1'b1; pend = 1'b1; rdy = 1'b0;
        observe(60, f, c);
        chk("R6 first pulse", f, 4);
        chk("R6 no reload", c, 1);
        release_all();
        // R9: new stall rearms
        pend = 1'b1; rdy = 1'b0;
        observe(10, f, c);
        chk("R9 rearm pulse", f, 4);
        release_all();
    endtask

    task automatic t_break_ready();
        int f, c;
        pre = 12'd2; lim = 12'd3;
        en = 1'b1; pend = 1'b1; rdy = 1'b0;
        observe(9, f, c);
        chk("R4 no pulse before ready", c, 0);
        rdy = 1'b1;
        observe(2, f, c);
        chk("R4 no pulse while ready", c, 0);
        rdy = 1'b0;
        observe(20, f, c);
        chk("R4 full restart after ready", f, 12);
        release_all();
        // pending falls mid-count
        pend = 1'b1; rdy = 1'b0;
        observe(10, f, c);
        pend = 1'b0;
        observe(1, f, c);
        chk("R4 no pulse with pending low", c, 0);
        pend = 1'b1;
        observe(20, f, c);
        chk("R4 full restart after pending", f, 12);
        release_all();
    endtask

    task automatic t_enable();
        int f, c;
        pre = 12'd2; lim = 12'd3;
        en = 1'b0; pend = 1'b1; rdy = 1'b0;
        observe(30, f, c);
        chk("R1 disabled never arms", c, 0);
        en = 1'b1;
        observe(6, f, c);
        en = 1'b0;
        observe(30, f, c);
        chk("R3 cleared mid-count", c, 0);
        en = 1'b1;
        observe(20, f, c);
        chk("R3 fresh count after enable", f, 12);
        release_all();
    endtask

    task automatic t_cfg_change();
        int f, c;
        pre = 12'd1; lim = 12'd2;
        en = 1'b1; pend = 1'b1; rdy = 1'b0;
        observe(2, f, c);
        pre = 12'd7; lim = 12'd7;
        observe(20, f, c);
        // two cycles already observed, expected at edge 6 overall
        chk("R7 change ignored", f + 2, 6);
        chk("R7 one pulse", c, 1);
        release_all();
        pend = 1'b1; rdy = 1'b0;
        observe(70, f, c);
        chk("R7 new values at next arm", f, 64);
        release_all();
    endtask

    initial begin
        t_reset();
        t_interval(1, 2, "R5 P1 T2");
        t_interval(0, 0, "R2 P0 T0");
        t_interval(0, 3, "R2 P0 T3");
        t_interval(3, 1, "R5 P3 T1");
        t_one_shot();
        t_break_ready();
        t_enable();
        t_cfg_change();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule